// File: doc/BRIEF.md
# Operate-Group Accumulator Unit

This unit carries out the first operate group of an accumulator machine's instruction set. Each instruction word holds a set of independent micro-operation bits. The unit applies every enabled operation to a 32-bit accumulator and a 1-bit link, always in one fixed sequence, and produces the new accumulator and link values in a single instruction. The available operations are:

- clearing the accumulator or the link,
- complementing either of them,
- incrementing the accumulator, with a carry out of the top bit toggling the link,
- a three-bit rotate field that selects one of:
  - a one-place or two-place rotate of the 33-bit link-plus-accumulator value,
  - an exchange of the accumulator halves,
  - an exchange of the nibbles inside each of the two low bytes,
  - a copy of the program counter into the accumulator.

The surrounding processor supplies the instruction word, the current accumulator, the link and the program counter, together with an enable. The unit returns the results from registers that update on the next clock edge. An instruction outside this group, or a cycle with the enable low, leaves the registered results as they were.

Top module: `opgrp_acc_unit`

## Requirements
- R1: While rst_n is low, acc_q is 0 and link_q is 0.
- R2: The unit acts only when all of these are true at a rising edge: exec_en is 1, instr[15:13] equals 3'b111, and instr[11] is 0. At any other edge, acc_q and link_q keep their previous values.
- R3: If an accepted instruction has instr[12:0] all zero, acc_q takes acc_in and link_q takes link_in.
- R4: Bit 0x0200 clears the accumulator and bit 0x0100 clears the link. These are the first operations applied.
- R5: Bit 0x0040 complements the accumulator and bit 0x0020 complements the link. Both act after the clears.
- R6: Bit 0x0001 adds one to the accumulator after the complements. A carry out of bit 31 toggles the link.
- R7: The rotate field is applied last and is written {RR=0x0010, RL=0x0004, RT=0x0002}. Code 100 rotates {link, acc} right by one. Code 101 rotates it right by two.
- R8: Code 010 rotates {link, acc} left by one. Code 011 rotates it left by two.
- R9: Code 001 exchanges acc[31:16] with acc[15:0] and leaves the link unchanged.
- R10: Code 110 swaps acc[15:12] with acc[11:8] and acc[7:4] with acc[3:0]. It leaves acc[31:16] and the link unchanged.
- R11: Code 111 loads the accumulator from pc_in and leaves the link unchanged.
- R12: Bits 0x1000, 0x0400, 0x0080, 0x0008 and instr[31:16] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute the presented instruction this cycle |
| instr | input | 32 | Instruction word |
| acc_in | input | 32 | Current accumulator |
| link_in | input | 1 | Current link |
| pc_in | input | 32 | Current program counter |
| acc_q | output | 32 | Registered new accumulator |
| link_q | output | 1 | Registered new link |

## Verification
Every result passes through exactly one register. A value presented at a falling edge therefore shows up on acc_q and link_q just after the next rising edge. Each scenario task drives its inputs at the falling edge, waits for one rising edge and samples 1 ns later. Hold cases present a rejected instruction whose operands differ from the last result. After that single edge, they confirm that the outputs still carry the earlier result.

// File: rtl/opgrp_pkg.sv
package opgrp_pkg;
    localparam int DATA_W = 32;

    // micro-operation bit positions within the instruction word
    localparam int B_CLR_AC = 9;
    localparam int B_CLR_L  = 8;
    localparam int B_CMP_AC = 6;
    localparam int B_CMP_L  = 5;
    localparam int B_RR     = 4;
    localparam int B_RL     = 2;
    localparam int B_RT     = 1;
    localparam int B_INC    = 0;
    localparam int B_GROUP  = 11;

    // rotate field code, written {RR, RL, RT}
    typedef enum logic [2:0] {
        ROT_NONE = 3'b000,
        ROT_HSW  = 3'b001,
        ROT_L1   = 3'b010,
        ROT_L2   = 3'b011,
        ROT_R1   = 3'b100,
        ROT_R2   = 3'b101,
        ROT_NIB  = 3'b110,
        ROT_PC   = 3'b111
    } rot_code_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              link;
    } acc_state_t;
endpackage

// File: rtl/opgrp_logic_stage.sv
module opgrp_logic_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic         link_i,
    input  logic         clr_ac,
    input  logic         clr_l,
    input  logic         cmp_ac,
    input  logic         cmp_l,
    input  logic         inc_ac,
    output logic [W-1:0] acc_o,
    output logic         link_o
);
    logic [W-1:0] a_clr, a_cmp;
    logic         l_clr, l_cmp;
    logic [W:0]   sum;

    always_comb begin
        a_clr  = clr_ac ? '0 : acc_i;
        l_clr  = clr_l ? 1'b0 : link_i;
        a_cmp  = cmp_ac ? ~a_clr : a_clr;
        l_cmp  = cmp_l ? ~l_clr : l_clr;
        sum    = {1'b0, a_cmp} + {{W{1'b0}}, inc_ac};
        acc_o  = sum[W-1:0];
        link_o = l_cmp ^ sum[W];
    end
endmodule

// File: rtl/opgrp_rotate_stage.sv
module opgrp_rotate_stage
    import opgrp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic         link_i,
    input  logic [2:0]   code,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] acc_o,
    output logic         link_o
);
    localparam int HALF  = W / 2;
    localparam int NPAIR = 2;

    logic [W:0]   v, r1, r2, l1, l2;
    logic [W-1:0] nib;

    assign v  = {link_i, acc_i};
    assign r1 = {v[0], v[W:1]};
    assign r2 = {v[1:0], v[W:2]};
    assign l1 = {v[W-1:0], v[W]};
    assign l2 = {v[W-2:0], v[W:W-1]};

    assign nib[W-1:8*NPAIR] = acc_i[W-1:8*NPAIR];
    for (genvar k = 0; k < NPAIR; k++) begin : g_nib
        assign nib[8*k+7 -: 4] = acc_i[8*k+3 -: 4];
        assign nib[8*k+3 -: 4] = acc_i[8*k+7 -: 4];
    end

    always_comb begin
        acc_o  = acc_i;
        link_o = link_i;
        unique case (rot_code_e'(code))
            ROT_R1:  {link_o, acc_o} = r1;
            ROT_R2:  {link_o, acc_o} = r2;
            ROT_L1:  {link_o, acc_o} = l1;
            ROT_L2:  {link_o, acc_o} = l2;
            ROT_HSW: acc_o = {acc_i[HALF-1:0], acc_i[W-1:HALF]};
            ROT_NIB: acc_o = nib;
            ROT_PC:  acc_o = pc_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/opgrp_acc_unit.sv
module opgrp_acc_unit
    import opgrp_pkg::*;
#(
    parameter int OP_LSB   = 13,
    parameter int OP_W     = 3,
    parameter int GROUP_OP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] acc_q,
    output logic              link_q
);
    localparam int OP_MSB = OP_LSB + OP_W - 1;

    acc_state_t        st_d, st_q;
    logic [DATA_W-1:0] acc_mid, acc_fin;
    logic              link_mid, link_fin;
    logic              accept;
    logic [2:0]        rot;
    logic              unused_bits;

    assign unused_bits = ^{instr[31:OP_MSB+1], instr[12], instr[10], instr[7], instr[3]};

    assign accept = exec_en
                 && (instr[OP_MSB:OP_LSB] == OP_W'(GROUP_OP))
                 && !instr[B_GROUP];
    assign rot = {instr[B_RR], instr[B_RL], instr[B_RT]};

    opgrp_logic_stage #(.W(DATA_W)) u_logic (
        .acc_i  (acc_in),
        .link_i (link_in),
        .clr_ac (instr[B_CLR_AC]),
        .clr_l  (instr[B_CLR_L]),
        .cmp_ac (instr[B_CMP_AC]),
        .cmp_l  (instr[B_CMP_L]),
        .inc_ac (instr[B_INC]),
        .acc_o  (acc_mid),
        .link_o (link_mid)
    );

    opgrp_rotate_stage #(.W(DATA_W)) u_rot (
        .acc_i  (acc_mid),
        .link_i (link_mid),
        .code   (rot),
        .pc_i   (pc_in),
        .acc_o  (acc_fin),
        .link_o (link_fin)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.acc  = acc_fin;
            st_d.link = link_fin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q  = st_q.acc;
    assign link_q = st_q.link;

    // R2: rejected cycles keep the registered results
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (acc_q == $past(acc_q)) && (link_q == $past(link_q)));

    // R3: empty micro-operation field passes the operands through
    a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr[12:0] == 13'h0)
        |=> (acc_q == $past(acc_in)) && (link_q == $past(link_in)));

    // R4: a lone clear empties the accumulator
    a_r4_clear_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr[12:0] == 13'h0200) |=> (acc_q == '0) && (link_q == $past(link_in)));

    // R7: single right rotate through the link
    a_r7_rot_right: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr[12:0] == 13'h0010)
        |=> (acc_q == {$past(link_in), $past(acc_in[DATA_W-1:1])}) && (link_q == $past(acc_in[0])));

    // R11: PC copy leaves the link alone
    a_r11_pc_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr[12:0] == 13'h0016)
        |=> (acc_q == $past(pc_in)) && (link_q == $past(link_in)));
endmodule

// File: tb/sim_opgrp_acc_unit.sv
`timescale 1ns/1ps
module sim_opgrp_acc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] acc_q;
    logic        link_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    opgrp_acc_unit u0 (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
        .acc_in(acc_in), .link_in(link_in), .pc_in(pc_in),
        .acc_q(acc_q), .link_q(link_q)
    );

    task automatic compare(string req, logic [31:0] exp_a, logic exp_l);
        n_chk++;
        if (acc_q !== exp_a || link_q !== exp_l) begin
            n_bad++;
            $display("FAIL %s: acc=%h link=%b expected acc=%h link=%b",
                     req, acc_q, link_q, exp_a, exp_l);
        end
    endtask

    // one accepted instruction, result checked one edge later
    task automatic run_op(string req, logic [12:0] low, logic [31:0] a, logic l,
                          logic [31:0] pc, logic [31:0] exp_a, logic exp_l);
        @(negedge clk);
        exec_en = 1'b1;
        instr   = {16'h0000, 3'b111, low};
        acc_in  = a;
        link_in = l;
        pc_in   = pc;
        @(posedge clk);
        #1;
        exec_en = 1'b0;
        compare(req, exp_a, exp_l);
    endtask

    // a rejected cycle must leave previous results in place
    task automatic run_hold(string req, logic en, logic [31:0] word,
                            logic [31:0] exp_a, logic exp_l);
        @(negedge clk);
        exec_en = en;
        instr   = word;
        acc_in  = 32'h1357_2468;
        link_in = ~exp_l;
        pc_in   = 32'h0000_0777;
        @(posedge clk);
        #1;
        exec_en = 1'b0;
        compare(req, exp_a, exp_l);
    endtask

    task automatic t_reset();
        @(negedge clk);
        compare("R1 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        run_op("R3 nop", 13'h0000, 32'h1234_5678, 1'b1, 32'h0, 32'h1234_5678, 1'b1);
        run_op("R4 clear acc", 13'h0200, 32'hDEAD_BEEF, 1'b1, 32'h0, 32'h0, 1'b1);
        run_op("R4 clear link", 13'h0100, 32'h5, 1'b1, 32'h0, 32'h5, 1'b0);
        run_op("R5 cmp acc", 13'h0040, 32'h0F0F_0000, 1'b0, 32'h0, 32'hF0F0_FFFF, 1'b0);
        run_op("R5 cmp link", 13'h0020, 32'h9, 1'b0, 32'h0, 32'h9, 1'b1);
        run_op("R5 clear then cmp link", 13'h0120, 32'h9, 1'b0, 32'h0, 32'h9, 1'b1);
        run_op("R6 inc carry", 13'h0001, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, 1'b1);
        run_op("R6 inc plain", 13'h0001, 32'h7, 1'b1, 32'h0, 32'h8, 1'b1);
        run_op("R6 clr cmp inc order", 13'h0241, 32'h1234_0000, 1'b0, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic t_rotate();
        run_op("R7 rotate right 1", 13'h0010, 32'h0000_0003, 1'b1, 32'h0, 32'h8000_0001, 1'b1);
        run_op("R7 rotate right 2", 13'h0012, 32'h0000_0003, 1'b0, 32'h0, 32'h8000_0000, 1'b1);
        run_op("R8 rotate left 1", 13'h0004, 32'h8000_0001, 1'b0, 32'h0, 32'h0000_0002, 1'b1);
        run_op("R8 rotate left 2", 13'h0006, 32'hC000_0000, 1'b0, 32'h0, 32'h0000_0001, 1'b1);
        run_op("R8 inc then rotate left", 13'h0005, 32'h7FFF_FFFF, 1'b0, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic t_swaps();
        run_op("R9 halfword swap", 13'h0002, 32'h1234_5678, 1'b1, 32'h0, 32'h5678_1234, 1'b1);
        run_op("R10 nibble swap", 13'h0014, 32'hAAAA_1234, 1'b0, 32'h0, 32'hAAAA_2143, 1'b0);
        run_op("R11 pc copy", 13'h0016, 32'h5555_5555, 1'b1, 32'h0000_0ABC, 32'h0000_0ABC, 1'b1);
    endtask

    task automatic t_ignored();
        run_op("R12 unused bits", 13'h1488, 32'h1357_9BDF, 1'b1, 32'h0, 32'h1357_9BDF, 1'b1);
        @(negedge clk);
        exec_en = 1'b1;
        instr   = 32'hFFFF_E020;
        acc_in  = 32'h0000_00AA;
        link_in = 1'b0;
        @(posedge clk);
        #1;
        exec_en = 1'b0;
        compare("R12 upper word ignored", 32'h0000_00AA, 1'b1);
    endtask

    task automatic t_hold();
        run_hold("R2 group bit set", 1'b1, 32'h0000_EA00, 32'h0000_00AA, 1'b1);
        run_hold("R2 other opcode", 1'b1, 32'h0000_A200, 32'h0000_00AA, 1'b1);
        run_hold("R2 enable low", 1'b0, 32'h0000_E200, 32'h0000_00AA, 1'b1);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_basic();
        t_rotate();
        t_swaps();
        t_ignored();
        t_hold();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: acc=%h link=%b expected completion", acc_q, link_q);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule